// File: doc/BRIEF.md
# Multi-Event Fragment Packer

This block sits on a readout board between the fragment formatters and the Ethernet MAC. Each trigger produces one fragment on the input stream, tagged with its event number. The packer groups a configurable number of consecutive fragments into a single outgoing message, which lowers the message rate by that factor. With eight fragments per message, a 40 MHz trigger stream becomes 5 MHz of messages.

Every message starts with a three-word header. The header carries the destination address, the first event number, the fragment count, a sequence-error flag and the payload length in bytes. Because the length must be known before the header goes out, fragments are held in internal FIFOs until the last fragment of the message has arrived. The destination is broadcast to all boards from the timing system. It is captured on the first accepted beat of each message and kept with that message until it has been sent. A hysteresis throttle tells the trigger system to hold off when the payload buffer is filling.

Top module: `frag_packer`

## Requirements
- R1: After reset `outValid` is 0, `throttle` is 0 and `inReady` is 1.
- R2: A message is framed as three header words followed by its fragments. `outSop` is set only on the first header word. Header word 0 is the destination. Header word 1 is {first event[31:16], fragment count[15:8], zeros[7:1], error[0]}. Header word 2 is {zeros[31:16], payload bytes[15:0]}.
- R3: Each fragment appears as a descriptor {byte length[31:16], event number[15:0]}, followed by its data words in arrival order. A message holds exactly `cfgPack` fragments, with `cfgPack` sampled on the first accepted beat of the message.
- R4: The payload byte count in header word 2 equals 4 times the fragment count plus 4 times the total number of data words in the message.
- R5: The destination is `inDest` as sampled on the first accepted beat of a message. Later changes to `inDest` within that message have no effect on it.
- R6: The error bit is 1 exactly when some fragment's event number differs from the previous fragment's number plus one, modulo 2^16. A wrap from 0xFFFF to 0x0000 counts as consecutive.
- R7: A beat with `inLast` and `inEmpty` both set is a zero-length fragment. It still counts toward the packing factor and is sent as a descriptor of length 0 with no data words.
- R8: `outEop` is set only on the final word of a message. When the last fragment has zero length, that final word is its descriptor.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outSop` and `outEop` stay unchanged.
- R10: `throttle` rises one cycle after the payload occupancy exceeds `cfgHi`. It falls one cycle after the occupancy drops below `cfgLo`. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Packer can take a beat |
| inData | input | 32 | Fragment data word |
| inLast | input | 1 | Final beat of a fragment |
| inEmpty | input | 1 | With inLast: zero-length fragment, no data |
| inEvt | input | 16 | Event number, held over the fragment, sampled on its last beat |
| inDest | input | 32 | Destination from the timing interface |
| cfgPack | input | 8 | Fragments per message, 1 to MAX_PACK |
| cfgHi | input | 9 | Throttle set threshold, in words |
| cfgLo | input | 9 | Throttle clear threshold, in words |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | MAC accepts the word |
| outData | output | 32 | Message word |
| outSop | output | 1 | First word of a message |
| outEop | output | 1 | Last word of a message |
| throttle | output | 1 | Hold-off request toward the trigger system |

## Verification
The assertions assume a few things about the inputs. `cfgLo` does not exceed `cfgHi`. `cfgPack` is nonzero and stays fixed within a message. A whole message fits in the payload buffer, because output starts only when a message is complete. The stimulus respects all of this: it uses packing factors of 1, 4, 8 and 2, keeps messages to a few dozen words, and holds the thresholds at 10 and 4 for the whole run. Output backpressure comes from a credit counter. This lets the bench stall the MAC side at a chosen word and then release it by an exact number of beats.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  localparam int WORD_W = 32;
  localparam int EVT_W  = 16;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = 8;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_HDR0, SEL_HDR1, SEL_HDR2, SEL_DESC, SEL_DATA
  } outSel_e;

  typedef struct packed {
    outSel_e sel;
    logic    popDesc;
    logic    popData;
    logic    popMsg;
  } strobe_t;

  typedef struct packed {
    logic [WORD_W-1:0] dest;
    logic [EVT_W-1:0]  firstEvt;
    logic [CNT_W-1:0]  count;
    logic              err;
    logic [LEN_W-1:0]  bytes;
  } msgRec_t;
endpackage

// File: rtl/fpk_fifo.sv
module fpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/fpk_ctrl.sv
module fpk_ctrl
  import fpk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             outReady,
  input  logic             msgEmpty,
  input  logic [CNT_W-1:0] headCount,
  input  logic [LEN_W-1:0] headLen,
  output strobe_t          stb,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop
);
  outSel_e          state;
  logic [CNT_W-1:0] fragLeft;
  logic [LEN_W-1:0] bytesLeft;
  logic             fire, lastFrag;

  assign outValid = (state != SEL_IDLE);
  assign fire     = outValid && outReady;
  assign lastFrag = (fragLeft == CNT_W'(1));
  assign outSop   = (state == SEL_HDR0);
  assign outEop   = ((state == SEL_DESC) && lastFrag && (headLen == '0)) ||
                    ((state == SEL_DATA) && lastFrag && (bytesLeft == LEN_W'(4)));

  always_comb begin
    stb.sel     = state;
    stb.popDesc = fire && (state == SEL_DESC);
    stb.popData = fire && (state == SEL_DATA);
    stb.popMsg  = fire && outEop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEL_IDLE;
      fragLeft  <= '0;
      bytesLeft <= '0;
    end else begin
      case (state)
        SEL_IDLE: if (!msgEmpty) state <= SEL_HDR0;
        SEL_HDR0: if (fire) state <= SEL_HDR1;
        SEL_HDR1: if (fire) state <= SEL_HDR2;
        SEL_HDR2: if (fire) begin
          state    <= SEL_DESC;
          fragLeft <= headCount;
        end
        SEL_DESC: if (fire) begin
          if (headLen == '0) begin
            if (lastFrag) state <= SEL_IDLE;
            else fragLeft <= fragLeft - CNT_W'(1);
          end else begin
            bytesLeft <= headLen;
            state     <= SEL_DATA;
          end
        end
        SEL_DATA: if (fire) begin
          if (bytesLeft == LEN_W'(4)) begin
            if (lastFrag) state <= SEL_IDLE;
            else begin
              fragLeft <= fragLeft - CNT_W'(1);
              state    <= SEL_DESC;
            end
          end else begin
            bytesLeft <= bytesLeft - LEN_W'(4);
          end
        end
        default: state <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpk_datapath.sv
module fpk_datapath
  import fpk_pkg::*;
#(
  parameter int DATA_DEPTH = 256,
  parameter int MAX_PACK   = 16,
  parameter int MSG_DEPTH  = 2,
  localparam int OCC_W     = $clog2(DATA_DEPTH + 1),
  localparam int DESC_DEPTH = 2 * MAX_PACK,
  localparam int DCW       = $clog2(DESC_DEPTH + 1),
  localparam int MCW       = $clog2(MSG_DEPTH + 1),
  localparam int REC_W     = $bits(msgRec_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  input  logic              inEmpty,
  input  logic [EVT_W-1:0]  inEvt,
  input  logic [WORD_W-1:0] inDest,
  input  logic [CNT_W-1:0]  cfgPack,
  input  logic [OCC_W-1:0]  cfgHi,
  input  logic [OCC_W-1:0]  cfgLo,
  input  strobe_t           stb,
  output logic [WORD_W-1:0] outData,
  output logic              msgEmpty,
  output logic [CNT_W-1:0]  headCount,
  output logic [LEN_W-1:0]  headLen,
  output logic              throttle,
  output logic [OCC_W-1:0]  occ
);
  // input-side accumulation state
  logic              inMsg;
  logic [CNT_W-1:0]  fragCnt;
  logic [LEN_W-1:0]  fragBytes;
  logic [EVT_W-1:0]  prevEvt, firstEvt;
  logic              errAcc;
  logic [LEN_W-1:0]  bytesAcc;
  logic [WORD_W-1:0] destHold;
  logic [CNT_W-1:0]  packHold;

  logic              accept, isFirstFrag, seqBad, lastOfMsg;
  logic [WORD_W-1:0] curDest;
  logic [CNT_W-1:0]  curPack;
  logic [LEN_W-1:0]  beatBytes, fragLen, totNext;
  logic [EVT_W-1:0]  firstNext;
  logic              errNext;
  msgRec_t           msgNew, msgHead;
  logic [REC_W-1:0]  msgHeadRaw;
  logic [WORD_W-1:0] descHead, dataHead;
  logic [DCW-1:0]    descCnt;
  logic [MCW-1:0]    msgCnt;
  logic              dataFull, descFull, msgFull;

  assign accept      = inValid && inReady;
  assign curDest     = inMsg ? destHold : inDest;
  assign curPack     = inMsg ? packHold : cfgPack;
  assign beatBytes   = inEmpty ? '0 : LEN_W'(4);
  assign fragLen     = fragBytes + beatBytes;
  assign isFirstFrag = (fragCnt == '0);
  assign seqBad      = !isFirstFrag && (inEvt != prevEvt + EVT_W'(1));
  assign errNext     = errAcc || seqBad;
  assign firstNext   = isFirstFrag ? inEvt : firstEvt;
  assign totNext     = bytesAcc + beatBytes + (inLast ? LEN_W'(4) : '0);
  assign lastOfMsg   = inLast && (fragCnt + CNT_W'(1) == curPack);

  always_comb begin
    msgNew.dest     = curDest;
    msgNew.firstEvt = firstNext;
    msgNew.count    = curPack;
    msgNew.err      = errNext;
    msgNew.bytes    = totNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMsg     <= 1'b0;
      fragCnt   <= '0;
      fragBytes <= '0;
      prevEvt   <= '0;
      firstEvt  <= '0;
      errAcc    <= 1'b0;
      bytesAcc  <= '0;
      destHold  <= '0;
      packHold  <= '0;
    end else if (accept) begin
      if (!inMsg) begin
        destHold <= inDest;
        packHold <= cfgPack;
      end
      inMsg     <= !lastOfMsg;
      fragBytes <= inLast ? '0 : fragLen;
      bytesAcc  <= (inLast && lastOfMsg) ? '0 : totNext;
      if (inLast) begin
        prevEvt <= inEvt;
        if (lastOfMsg) begin
          fragCnt <= '0;
          errAcc  <= 1'b0;
        end else begin
          fragCnt  <= fragCnt + CNT_W'(1);
          errAcc   <= errNext;
          firstEvt <= firstNext;
        end
      end
    end
  end

  fpk_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) dataQ (
    .clk(clk), .rstN(rstN),
    .push(accept && !inEmpty), .din(inData),
    .pop(stb.popData), .dout(dataHead), .count(occ)
  );

  fpk_fifo #(.W(WORD_W), .DEPTH(DESC_DEPTH)) descQ (
    .clk(clk), .rstN(rstN),
    .push(accept && inLast), .din({fragLen, inEvt}),
    .pop(stb.popDesc), .dout(descHead), .count(descCnt)
  );

  fpk_fifo #(.W(REC_W), .DEPTH(MSG_DEPTH)) msgQ (
    .clk(clk), .rstN(rstN),
    .push(accept && lastOfMsg), .din(msgNew),
    .pop(stb.popMsg), .dout(msgHeadRaw), .count(msgCnt)
  );

  assign msgHead   = msgRec_t'(msgHeadRaw);
  assign dataFull  = (occ == OCC_W'(DATA_DEPTH));
  assign descFull  = (descCnt == DCW'(DESC_DEPTH));
  assign msgFull   = (msgCnt == MCW'(MSG_DEPTH));
  assign inReady   = !dataFull && !descFull && !msgFull;
  assign msgEmpty  = (msgCnt == '0);
  assign headCount = msgHead.count;
  assign headLen   = descHead[WORD_W-1:EVT_W];

  always_comb begin
    case (stb.sel)
      SEL_HDR0: outData = msgHead.dest;
      SEL_HDR1: outData = {msgHead.firstEvt, msgHead.count, 7'b0, msgHead.err};
      SEL_HDR2: outData = {{(WORD_W-LEN_W){1'b0}}, msgHead.bytes};
      SEL_DESC: outData = descHead;
      SEL_DATA: outData = dataHead;
      default:  outData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             throttle <= 1'b0;
    else if (occ > cfgHi)  throttle <= 1'b1;
    else if (occ < cfgLo)  throttle <= 1'b0;
  end
endmodule

// File: rtl/frag_packer.sv
module frag_packer
  import fpk_pkg::*;
#(
  parameter int DATA_DEPTH = 256,
  parameter int MAX_PACK   = 16,
  parameter int MSG_DEPTH  = 2,
  localparam int OCC_W     = $clog2(DATA_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  input  logic              inEmpty,
  input  logic [EVT_W-1:0]  inEvt,
  input  logic [WORD_W-1:0] inDest,
  input  logic [CNT_W-1:0]  cfgPack,
  input  logic [OCC_W-1:0]  cfgHi,
  input  logic [OCC_W-1:0]  cfgLo,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  output logic              throttle
);
  strobe_t          stb;
  logic             msgEmpty;
  logic [CNT_W-1:0] headCount;
  logic [LEN_W-1:0] headLen;
  logic [OCC_W-1:0] occ;

  fpk_datapath #(
    .DATA_DEPTH(DATA_DEPTH), .MAX_PACK(MAX_PACK), .MSG_DEPTH(MSG_DEPTH)
  ) dp (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .inEmpty(inEmpty), .inEvt(inEvt), .inDest(inDest),
    .cfgPack(cfgPack), .cfgHi(cfgHi), .cfgLo(cfgLo),
    .stb(stb), .outData(outData), .msgEmpty(msgEmpty),
    .headCount(headCount), .headLen(headLen),
    .throttle(throttle), .occ(occ)
  );

  fpk_ctrl ctl (
    .clk(clk), .rstN(rstN), .outReady(outReady),
    .msgEmpty(msgEmpty), .headCount(headCount), .headLen(headLen),
    .stb(stb), .outValid(outValid), .outSop(outSop), .outEop(outEop)
  );
endmodule

// File: rtl/frag_packer_checker.sv
module frag_packer_checker #(
  parameter int OCC_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outReady,
  input logic [31:0]      outData,
  input logic             outSop,
  input logic             outEop,
  input logic             throttle,
  input logic [OCC_W-1:0] occ,
  input logic [OCC_W-1:0] cfgHi,
  input logic [OCC_W-1:0] cfgLo
);
  logic inPkt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inPkt <= 1'b0;
    else if (outValid && outReady && outEop) inPkt <= 1'b0;
    else if (outValid && outReady && outSop) inPkt <= 1'b1;
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop) && $stable(outEop))); // R9

  AST_SOP_OUTSIDE_PKT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> !inPkt); // R2

  AST_BODY_INSIDE_PKT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSop) |-> inPkt); // R8

  AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outSop && outEop)); // R2

  AST_THROTTLE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(throttle) |-> ($past(occ) > $past(cfgHi))); // R10

  AST_THROTTLE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(throttle) |-> ($past(occ) < $past(cfgLo))); // R10
endmodule

bind frag_packer frag_packer_checker #(.OCC_W(OCC_W)) chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outSop(outSop), .outEop(outEop),
  .throttle(throttle), .occ(occ), .cfgHi(cfgHi), .cfgLo(cfgLo)
);

// File: tb/frag_packer_test.sv
module frag_packer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, inEmpty = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0, inDest = '0;
  logic [15:0] inEvt = '0;
  logic [7:0]  cfgPack = 8'd1;
  logic [8:0]  cfgHi = 9'd10, cfgLo = 9'd4;
  logic        outValid, outReady = 1'b0, outSop, outEop, throttle;
  logic [31:0] outData;

  int compared = 0, mismatched = 0;
  int credit = -1;

  logic [33:0] expQ[$];
  string       expTag[$];

  // model state of the message being assembled
  int          mCnt = 0, mPack = 0;
  logic [31:0] mDest;
  logic [15:0] mFirst, mPrev;
  logic        mErr;
  int          mBytes;
  logic [31:0] bodyD[$];
  string       bodyT[$];

  // {pack[63:56], evt[55:40], words[39:32], dest[31:0]}
  localparam logic [63:0] TBL [16] = '{
    {8'd4, 16'd100,    8'd2, 32'hA000_0001},
    {8'd4, 16'd101,    8'd0, 32'hDEAD_0001},
    {8'd4, 16'd102,    8'd5, 32'hDEAD_0002},
    {8'd4, 16'd103,    8'd1, 32'hDEAD_0003},
    {8'd4, 16'd200,    8'd3, 32'hB000_0002},
    {8'd4, 16'd201,    8'd1, 32'hDEAD_0004},
    {8'd4, 16'd203,    8'd0, 32'hDEAD_0005},
    {8'd4, 16'd204,    8'd2, 32'hDEAD_0006},
    {8'd8, 16'hFFFC,   8'd1, 32'hC000_0003},
    {8'd8, 16'hFFFD,   8'd2, 32'hDEAD_0007},
    {8'd8, 16'hFFFE,   8'd0, 32'hDEAD_0008},
    {8'd8, 16'hFFFF,   8'd1, 32'hDEAD_0009},
    {8'd8, 16'h0000,   8'd3, 32'hDEAD_000A},
    {8'd8, 16'h0001,   8'd1, 32'hDEAD_000B},
    {8'd8, 16'h0002,   8'd2, 32'hDEAD_000C},
    {8'd8, 16'h0003,   8'd0, 32'hDEAD_000D}
  };

  frag_packer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inEmpty(inEmpty), .inEvt(inEvt),
    .inDest(inDest), .cfgPack(cfgPack), .cfgHi(cfgHi), .cfgLo(cfgLo),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSop(outSop), .outEop(outEop), .throttle(throttle)
  );

  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // output monitor with credit-based backpressure
  always @(negedge clk) begin
    outReady = (credit != 0);
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected word", {outSop, outEop, outData}, 34'h0);
      end else begin
        logic [33:0] e;
        string t;
        e = expQ.pop_front();
        t = expTag.pop_front();
        check({outSop, outEop, outData} === e, t, {outSop, outEop, outData}, e);
      end
      if (credit > 0) credit--;
    end
  end

  function automatic logic [31:0] dataWord(input logic [15:0] evt, input int i);
    return {evt, 8'h5A, 8'(i)};
  endfunction

  task automatic modelFrag(input int pack, input logic [15:0] evt, input int nw, input logic [31:0] dest);
    if (mCnt == 0) begin
      mDest = dest; mPack = pack; mFirst = evt; mErr = 1'b0; mBytes = 0;
      bodyD.delete(); bodyT.delete();
    end else if (evt != mPrev + 16'd1) begin
      mErr = 1'b1;
    end
    mPrev = evt;
    bodyD.push_back({16'(nw * 4), evt});
    bodyT.push_back(nw == 0 ? "R7 zero-length descriptor" : "R3 descriptor");
    for (int i = 0; i < nw; i++) begin
      bodyD.push_back(dataWord(evt, i));
      bodyT.push_back("R3 data word");
    end
    mBytes += 4 + 4 * nw;
    mCnt++;
    if (mCnt == mPack) begin
      expQ.push_back({2'b10, mDest});                                    expTag.push_back("R5 header destination");
      expQ.push_back({2'b00, mFirst, 8'(mPack), 7'b0, mErr});            expTag.push_back("R6 header event/count/error");
      expQ.push_back({2'b00, 16'h0, 16'(mBytes)});                       expTag.push_back("R4 header byte count");
      for (int i = 0; i < bodyD.size(); i++) begin
        logic last;
        last = (i == bodyD.size() - 1);
        expQ.push_back({1'b0, last, bodyD[i]});
        expTag.push_back(last ? {bodyT[i], " R8 end marker"} : bodyT[i]);
      end
      mCnt = 0;
    end
  endtask

  task automatic sendFrag(input int pack, input logic [15:0] evt, input int nw, input logic [31:0] dest);
    int beats;
    beats = (nw == 0) ? 1 : nw;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inEmpty = (nw == 0);
      inLast  = (i == beats - 1);
      inData  = (nw == 0) ? 32'hFFFF_FFFF : dataWord(evt, i);
      inEvt   = evt;
      cfgPack = 8'(pack);
      inDest  = (i == 0) ? dest : ~dest;
      while (!inReady) @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inDest  = 32'h1234_5678;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (expQ.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] heldData;
    logic        heldSop;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid after reset", {33'b0, outValid}, 34'h0);
    check(throttle == 1'b0, "R1 throttle after reset", {33'b0, throttle}, 34'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady after reset", {33'b0, inReady}, 34'h1);

    // table walk: three messages (clean, sequence gap, wrap + zero-length tail)
    for (int v = 0; v < 16; v++) begin
      modelFrag(int'(TBL[v][63:56]), TBL[v][55:40], int'(TBL[v][39:32]), TBL[v][31:0]);
      sendFrag(int'(TBL[v][63:56]), TBL[v][55:40], int'(TBL[v][39:32]), TBL[v][31:0]);
    end
    drain();
    check(expQ.size() == 0, "R3 all table messages emitted", 34'(expQ.size()), 34'h0);

    // R10 / R9: throttle with output stalled
    credit = 0;
    modelFrag(2, 16'd500, 10, 32'h7000_0001);
    sendFrag(2, 16'd500, 10, 32'h7000_0001);
    repeat (2) @(negedge clk);
    check(throttle == 1'b0, "R10 occupancy at mark, no throttle", {33'b0, throttle}, 34'h0);
    modelFrag(2, 16'd501, 2, 32'hDEAD_7777);
    sendFrag(2, 16'd501, 2, 32'hDEAD_7777);
    repeat (2) @(negedge clk);
    check(throttle == 1'b1, "R10 occupancy above mark", {33'b0, throttle}, 34'h1);
    heldData = outData;
    heldSop  = outSop;
    repeat (3) @(negedge clk);
    check(outValid && outData == heldData && outSop == heldSop, "R9 word held under stall",
          {outSop, outValid, outData}, {heldSop, 1'b1, heldData});
    credit = 10;
    while (credit != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(throttle == 1'b1, "R10 hysteresis between marks", {33'b0, throttle}, 34'h1);
    credit = -1;
    drain();
    check(throttle == 1'b0, "R10 release below low mark", {33'b0, throttle}, 34'h0);

    // R7: single zero-length fragment, packing factor 1
    modelFrag(1, 16'd42, 0, 32'h0BAD_F00D);
    sendFrag(1, 16'd42, 0, 32'h0BAD_F00D);
    drain();
    check(expQ.size() == 0, "R7 zero-length message emitted", 34'(expQ.size()), 34'h0);
    check(inReady == 1'b1 && outValid == 1'b0, "R3 idle after last message",
          {32'b0, inReady, outValid}, 34'h2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule